// File: doc/BRIEF.md
# SCSI Initiator Bus Phase Register Model

This block is the processor-side register file of a simplified SCSI initiator controller. Eight byte-wide registers are selected by the low three bits of an address. Writes to the initiator command, mode, target command and start-DMA registers update a bus status byte and a bus-and-status byte as side effects. These two bytes model the bus phase, BSY, REQ, phase match and DMA mode. The bus itself is never sampled: each flag moves only in response to particular written values.

During selection, a byte written to the output data register carries a one-hot target bit. The block encodes that bit into a target number. That number then picks a line of the device-present vector when software claims the bus, and the line decides whether BSY is set. In the data-in phase, reads of the current-data register return the byte offered on the device data input.

Top module: `scsi_phase_regs`

## Requirements
- R1: Reset (synchronous, active high) clears all eight registers, the read data output and the captured target number to zero.
- R2: Only address bits 2:0 select a register. Offsets 4, 6 and 7 store written bytes as plain storage, and a later read at the same offset returns that byte.
- R3: Writing offset 3 copies data bits 2:0 into the phase field (bits 4:2 of the bus status byte at offset 4). It also sets REQ (bit 5, 0x20) in that byte and phase match (bit 3, 0x08) in the bus-and-status byte at offset 5.
- R4: Writing 0x00 to offset 1 clears BSY (bit 6, 0x40 of offset 4). Writing 0x05 to offset 1 sets BSY when device_present[target] is 1 and clears it otherwise.
- R5: Writing exactly 0x01 to offset 1 sets REQ. Any write to offset 1 with bit 4 set clears REQ.
- R6: Writing 0x02 to offset 2 sets DMA mode (bit 6, 0x40 of offset 5), and writing 0x00 clears it. Writing 0x01 to offset 2 sets bit 6 and clears bit 5 of offset 1. In every case offset 2 stores the written byte.
- R7: Any write to offset 5 leaves the bus-and-status byte equal to 0x48, whatever the data.
- R8: While offset 1 holds 0x04, a write to offset 0 is a selection. Bit 7 of the data is cleared before it is stored. A remaining single bit 0x01, 0x02 up to 0x40 sets the target number to 0 through 6.
- R9: The target number is unchanged by a selection byte that is not one of those single bits, and by any write made outside selection.
- R10: When the phase field is 1 (bus status bits 4:2 = 001), a read of offset 0 returns the device data input. In any other phase it returns the stored byte.
- R11: Read data is registered. It updates in the cycle after a read strobe and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address; bits 2:0 decode |
| wdata | input | 8 | Write data |
| dev_data | input | 8 | Byte offered by the target in the data-in phase |
| dev_present | input | 2**ID_W | One bit per target number, 1 = device present |
| rdata | output | 8 | Registered read data |
| target_id | output | ID_W | Target number captured during selection |

## Verification
The properties assume that the strobes, address and data are known values whenever reset is low. They also assume the device-present vector is steady around any bus-claim write, because the BSY outcome is judged against the line that the captured target number picks. The stimulus drives every input on the falling clock edge and keeps all of them at defined values from time zero, with reset asserted first. The sequence moves the phase, the selection register and the target number in a fixed order, so each flag change is provoked by a single known write.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  localparam int REG_CNT = 8;
  localparam int OFF_W   = $clog2(REG_CNT);

  typedef enum logic [OFF_W-1:0] {
    OFF_DATA  = 3'd0,
    OFF_ICMD  = 3'd1,
    OFF_MODE  = 3'd2,
    OFF_TCMD  = 3'd3,
    OFF_BSTAT = 3'd4,
    OFF_BNS   = 3'd5,
    OFF_AUX6  = 3'd6,
    OFF_AUX7  = 3'd7
  } reg_off_e;

  // bus status byte fields
  localparam int BS_BSY = 6;
  localparam int BS_REQ = 5;
  localparam int PH_HI  = 4;
  localparam int PH_LO  = 2;
  localparam logic [2:0] PH_DATA_IN = 3'd1;

  // bus-and-status byte fields
  localparam int BNS_DMA = 6;
  localparam int BNS_PM  = 3;
  localparam logic [7:0] BNS_DMA_GO = 8'h48;

  // initiator command fields and values
  localparam int IC_ARB  = 6;
  localparam int IC_LOST = 5;
  localparam int IC_ACK  = 4;
  localparam logic [7:0] IC_RELEASE = 8'h00;
  localparam logic [7:0] IC_DBUS    = 8'h01;
  localparam logic [7:0] IC_SELECT  = 8'h04;
  localparam logic [7:0] IC_CLAIM   = 8'h05;

  // mode values
  localparam logic [7:0] MD_IDLE = 8'h00;
  localparam logic [7:0] MD_ARB  = 8'h01;
  localparam logic [7:0] MD_DMA  = 8'h02;
endpackage

// File: rtl/scsi_sel_decode.sv
module scsi_sel_decode #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [DATA_W-1:0] sel_byte,
  output logic              hit,
  output logic [ID_W-1:0]   id
);
  localparam int SCAN = DATA_W - 1;

  logic [DATA_W-1:0] masked;

  always_comb begin
    masked = sel_byte;
    masked[DATA_W-1] = 1'b0;
    hit = 1'b0;
    id  = '0;
    for (int i = 0; i < SCAN; i++) begin
      if (masked == (DATA_W'(1) << i)) begin
        hit = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/scsi_status_next.sv
module scsi_status_next
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  reg_off_e          off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_here,
  input  logic [DATA_W-1:0] icmd_q,
  input  logic [DATA_W-1:0] bstat_q,
  input  logic [DATA_W-1:0] bns_q,
  output logic [DATA_W-1:0] icmd_side,
  output logic [DATA_W-1:0] bstat_side,
  output logic [DATA_W-1:0] bns_side
);
  always_comb begin
    icmd_side  = icmd_q;
    bstat_side = bstat_q;
    bns_side   = bns_q;
    if (wr_en) begin
      unique case (off)
        OFF_ICMD: begin
          if (wdata == IC_RELEASE) bstat_side[BS_BSY] = 1'b0;
          if (wdata == IC_CLAIM)   bstat_side[BS_BSY] = dev_here;
          if (wdata == IC_DBUS)    bstat_side[BS_REQ] = 1'b1;
          if (wdata[IC_ACK])       bstat_side[BS_REQ] = 1'b0;
        end
        OFF_MODE: begin
          if (wdata == MD_DMA)  bns_side[BNS_DMA] = 1'b1;
          if (wdata == MD_IDLE) bns_side[BNS_DMA] = 1'b0;
          if (wdata == MD_ARB) begin
            icmd_side[IC_ARB]  = 1'b1;
            icmd_side[IC_LOST] = 1'b0;
          end
        end
        OFF_TCMD: begin
          bstat_side[PH_HI:PH_LO] = wdata[2:0];
          bstat_side[BS_REQ]      = 1'b1;
          bns_side[BNS_PM]        = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  reg_off_e                       off,
  input  logic [DATA_W-1:0]              store_byte,
  input  logic [DATA_W-1:0]              icmd_side,
  input  logic [DATA_W-1:0]              bstat_side,
  input  logic [DATA_W-1:0]              bns_side,
  output logic [REG_CNT-1:0][DATA_W-1:0] regs_q
);
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic              wr_hit;
    logic [DATA_W-1:0] nxt;

    assign wr_hit = wr_en && (off == reg_off_e'(g));

    if (g == int'(OFF_ICMD)) begin : g_icmd
      assign nxt = wr_hit ? store_byte : icmd_side;
    end else if (g == int'(OFF_BSTAT)) begin : g_bstat
      assign nxt = wr_hit ? store_byte : bstat_side;
    end else if (g == int'(OFF_BNS)) begin : g_bns
      // the DMA start write shares this offset and wins over the plain store
      assign nxt = wr_hit ? DATA_W'(BNS_DMA_GO) : bns_side;
    end else begin : g_plain
      assign nxt = wr_hit ? store_byte : regs_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else     regs_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/scsi_phase_regs.sv
module scsi_phase_regs
  import scsi_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic [7:0]           dev_data,
  input  logic [(1<<ID_W)-1:0] dev_present,
  output logic [7:0]           rdata,
  output logic [ID_W-1:0]      target_id
);
  localparam int DATA_W = 8;

  reg_off_e                       off;
  logic [REG_CNT-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]              icmd_q, bstat_q, bns_q;
  logic [DATA_W-1:0]              icmd_side, bstat_side, bns_side;
  logic [DATA_W-1:0]              store_byte;
  logic                           selecting;
  logic                           sel_hit;
  logic [ID_W-1:0]                sel_id;
  logic [ID_W-1:0]                tid_q;
  logic [DATA_W-1:0]              rdata_q;

  assign off       = reg_off_e'(addr[OFF_W-1:0]);
  assign icmd_q    = regs_q[OFF_ICMD];
  assign bstat_q   = regs_q[OFF_BSTAT];
  assign bns_q     = regs_q[OFF_BNS];
  assign selecting = wr_en && (off == OFF_DATA) && (icmd_q == IC_SELECT);

  always_comb begin
    store_byte = wdata;
    if (selecting) store_byte[DATA_W-1] = 1'b0;
  end

  scsi_sel_decode #(.DATA_W(DATA_W), .ID_W(ID_W)) u_sel (
    .sel_byte (wdata),
    .hit      (sel_hit),
    .id       (sel_id)
  );

  scsi_status_next #(.DATA_W(DATA_W)) u_next (
    .wr_en      (wr_en),
    .off        (off),
    .wdata      (wdata),
    .dev_here   (dev_present[tid_q]),
    .icmd_q     (icmd_q),
    .bstat_q    (bstat_q),
    .bns_q      (bns_q),
    .icmd_side  (icmd_side),
    .bstat_side (bstat_side),
    .bns_side   (bns_side)
  );

  scsi_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .off        (off),
    .store_byte (store_byte),
    .icmd_side  (icmd_side),
    .bstat_side (bstat_side),
    .bns_side   (bns_side),
    .regs_q     (regs_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                      tid_q <= '0;
    else if (selecting && sel_hit) tid_q <= sel_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (off == OFF_DATA && bstat_q[PH_HI:PH_LO] == PH_DATA_IN) rdata_q <= dev_data;
      else                                                       rdata_q <= regs_q[off];
    end
  end

  assign rdata     = rdata_q;
  assign target_id = tid_q;
endmodule

// File: rtl/scsi_phase_regs_chk.sv
module scsi_phase_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [ID_W-1:0]   target_id,
  input logic [7:0]        icmd_q,
  input logic [7:0]        bstat_q,
  input logic [7:0]        bns_q
);
  logic [2:0] off;
  assign off = addr[2:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rdata == 8'h00 && target_id == '0 && bstat_q == 8'h00 && bns_q == 8'h00));

  // R3
  tcmd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 3'd3) |=>
      (bstat_q[4:2] == $past(wdata[2:0]) && bstat_q[5] && bns_q[3]));

  // R4
  release_bsy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 3'd1 && wdata == 8'h00) |=> !bstat_q[6]);

  // R5
  ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 3'd1 && wdata[4]) |=> !bstat_q[5]);

  // R6
  dma_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 3'd2 && wdata == 8'h02) |=> bns_q[6]);

  // R7
  dma_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 3'd5) |=> bns_q == 8'h48);

  // R9
  tid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && off == 3'd0 && icmd_q == 8'h04)) |=> $stable(target_id));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind scsi_phase_regs scsi_phase_regs_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .target_id (target_id),
  .icmd_q    (icmd_q),
  .bstat_q   (bstat_q),
  .bns_q     (bns_q)
);

// File: tb/test_scsi_phase_regs.sv
`timescale 1ns/1ps
module test_scsi_phase_regs;
  localparam int ADDR_W = 8;
  localparam int ID_W   = 3;
  localparam int NV     = 52;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0;
  logic                 rd_en = 1'b0;
  logic [ADDR_W-1:0]    addr = '0;
  logic [7:0]           wdata = '0;
  logic [7:0]           dev_data = 8'hC3;
  logic [(1<<ID_W)-1:0] dev_present = 8'b0010_0100;
  logic [7:0]           rdata;
  logic [ID_W-1:0]      target_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  scsi_phase_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W)) i_scsi_phase_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dev_data(dev_data), .dev_present(dev_present),
    .rdata(rdata), .target_id(target_id)
  );

  // {write, addr, data, expected read, expected target, requirement}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 8'h03, 8'h02, 8'h00, 3'd0, 4'd3},   // R3 enter command phase
    {1'b0, 8'h04, 8'h00, 8'h28, 3'd0, 4'd3},
    {1'b0, 8'h05, 8'h00, 8'h08, 3'd0, 4'd3},
    {1'b0, 8'h03, 8'h00, 8'h02, 3'd0, 4'd2},
    {1'b1, 8'h01, 8'h04, 8'h00, 3'd0, 4'd8},   // R8 selection armed
    {1'b1, 8'h00, 8'hA0, 8'h00, 3'd5, 4'd8},
    {1'b0, 8'h00, 8'h00, 8'h20, 3'd5, 4'd8},
    {1'b1, 8'h01, 8'h05, 8'h00, 3'd5, 4'd4},   // R4 claim, device 5 present
    {1'b0, 8'h04, 8'h00, 8'h68, 3'd5, 4'd4},
    {1'b1, 8'h01, 8'h11, 8'h00, 3'd5, 4'd5},   // R5 ack drops REQ
    {1'b0, 8'h04, 8'h00, 8'h48, 3'd5, 4'd5},
    {1'b1, 8'h01, 8'h01, 8'h00, 3'd5, 4'd5},
    {1'b0, 8'h04, 8'h00, 8'h68, 3'd5, 4'd5},
    {1'b1, 8'h01, 8'h00, 8'h00, 3'd5, 4'd4},   // R4 release
    {1'b0, 8'h04, 8'h00, 8'h28, 3'd5, 4'd4},
    {1'b0, 8'h01, 8'h00, 8'h00, 3'd5, 4'd2},
    {1'b1, 8'h02, 8'h02, 8'h00, 3'd5, 4'd6},   // R6 DMA on/off
    {1'b0, 8'h05, 8'h00, 8'h48, 3'd5, 4'd6},
    {1'b1, 8'h02, 8'h00, 8'h00, 3'd5, 4'd6},
    {1'b0, 8'h05, 8'h00, 8'h08, 3'd5, 4'd6},
    {1'b1, 8'h01, 8'h20, 8'h00, 3'd5, 4'd6},
    {1'b1, 8'h02, 8'h01, 8'h00, 3'd5, 4'd6},   // R6 arbitrate
    {1'b0, 8'h01, 8'h00, 8'h40, 3'd5, 4'd6},
    {1'b0, 8'h02, 8'h00, 8'h01, 3'd5, 4'd6},
    {1'b1, 8'h0D, 8'h12, 8'h00, 3'd5, 4'd7},   // R7 via aliased address
    {1'b0, 8'h05, 8'h00, 8'h48, 3'd5, 4'd7},
    {1'b1, 8'h0E, 8'h5A, 8'h00, 3'd5, 4'd2},   // R2 aliasing
    {1'b0, 8'h06, 8'h00, 8'h5A, 3'd5, 4'd2},
    {1'b0, 8'h0E, 8'h00, 8'h5A, 3'd5, 4'd2},
    {1'b1, 8'h01, 8'h04, 8'h00, 3'd5, 4'd9},   // R9 non one-hot
    {1'b1, 8'h00, 8'h03, 8'h00, 3'd5, 4'd9},
    {1'b0, 8'h00, 8'h00, 8'h03, 3'd5, 4'd9},
    {1'b1, 8'h00, 8'h84, 8'h00, 3'd2, 4'd8},
    {1'b0, 8'h00, 8'h00, 8'h04, 3'd2, 4'd8},
    {1'b1, 8'h01, 8'h05, 8'h00, 3'd2, 4'd4},
    {1'b0, 8'h04, 8'h00, 8'h68, 3'd2, 4'd4},
    {1'b1, 8'h01, 8'h04, 8'h00, 3'd2, 4'd9},
    {1'b1, 8'h00, 8'h80, 8'h00, 3'd2, 4'd9},
    {1'b0, 8'h00, 8'h00, 8'h00, 3'd2, 4'd9},
    {1'b1, 8'h00, 8'h40, 8'h00, 3'd6, 4'd8},
    {1'b1, 8'h01, 8'h05, 8'h00, 3'd6, 4'd4},   // R4 device 6 absent
    {1'b0, 8'h04, 8'h00, 8'h28, 3'd6, 4'd4},
    {1'b1, 8'h01, 8'h00, 8'h00, 3'd6, 4'd9},
    {1'b1, 8'h00, 8'h01, 8'h00, 3'd6, 4'd9},
    {1'b0, 8'h00, 8'h00, 8'h01, 3'd6, 4'd9},
    {1'b1, 8'h03, 8'h01, 8'h00, 3'd6, 4'd10},  // R10 data-in phase
    {1'b0, 8'h00, 8'h00, 8'hC3, 3'd6, 4'd10},
    {1'b0, 8'h04, 8'h00, 8'h24, 3'd6, 4'd3},
    {1'b1, 8'h03, 8'h00, 8'h00, 3'd6, 4'd10},
    {1'b0, 8'h00, 8'h00, 8'h01, 3'd6, 4'd10},
    {1'b1, 8'h0C, 8'h9C, 8'h00, 3'd6, 4'd2},
    {1'b0, 8'h04, 8'h00, 8'h9C, 3'd6, 4'd2}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, rdata, 8'h00, "rdata after reset");
    check(1, {5'd0, target_id}, 8'h00, "target after reset");

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      if (v[31]) do_write(v[30:23], v[22:15]);
      else begin
        do_read(v[30:23], q);
        check(int'(v[3:0]), q, v[14:7], $sformatf("vector %0d read", k));
      end
      check(int'(v[3:0]), {5'd0, target_id}, {5'd0, v[6:4]}, $sformatf("vector %0d target", k));
    end

    // R11 read data holds without a read strobe
    do_write(8'h07, 8'h77);
    do_read(8'h07, q);
    check(11, q, 8'h77, "read offset 7");
    do_write(8'h07, 8'h11);
    @(negedge clk);
    check(11, rdata, 8'h77, "hold without read");
    do_read(8'h07, q);
    check(11, q, 8'h11, "next read");

    // R1 reset in the middle of operation clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1, rdata, 8'h00, "rdata after mid reset");
    check(1, {5'd0, target_id}, 8'h00, "target after mid reset");
    for (int r = 0; r < 8; r++) begin
      do_read(8'(r), q);
      check(1, q, 8'h00, $sformatf("register %0d after reset", r));
    end
    finish_run();
  end
endmodule